// File: doc/BRIEF.md
# Three-Phase Deadtime Inserter

This block turns three single-bit PWM leg commands into six switch drives: one high-side and one low-side signal per phase. The high-side drive copies the command level and the low-side drive is its complement. Whenever a command changes, both drives of that phase go low and stay low for a fixed number of clock cycles before the opposite drive turns on. The two switches of a leg therefore never conduct together.

The same per-phase counter also filters noise on the command. Any change of the synchronized command restarts the count. A pulse shorter than the deadtime never reaches a drive; it only stretches the time during which both drives are low. Each phase has its own enable and there is one global output enable. Both are pure combinational gates on the drives. The counters keep running while a phase is gated off, so releasing an enable shows the counter's present state on the drives at once.

Top module: `pwm_deadtime3`

## Requirements
- R1: Once a phase has settled, its high-side drive equals the phase command and its low-side drive is the inverse of the command.
- R2: The high-side and low-side drives of one phase are never both 1.
- R3: Between one drive of a phase falling and the other drive of that phase rising, both drives are 0 for exactly DEAD_CYC (default 8) clock cycles.
- R4: A command change at the port reaches the deadtime logic through a two-flop synchronizer. Both drives of that phase clear on the third rising clock edge after the change, and the new drive rises on the eleventh rising edge. Drives of the other phases do not change.
- R5: A command pulse shorter than DEAD_CYC cycles never asserts the opposite drive. Both drives stay 0 until the command has been stable for DEAD_CYC cycles after its last change, so the rise comes eleven edges after the final change.
- R6: While rst_n is 0, all six drives are 0. After release, no drive rises before DEAD_CYC rising edges have passed. With all commands at 0, every low-side drive rises on the eighth edge after release.
- R7: A per-phase enable at 0 forces both drives of that phase to 0 at once, without waiting for a clock edge, and leaves the other phases unaffected.
- R8: out_en at 0 forces all six drives to 0 at once, without waiting for a clock edge.
- R9: A phase's counter keeps running while its enable is 0. Raising the enable immediately shows that counter's state: both drives 0 if the deadtime is still running, the settled drive if it has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Deadtime counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ph_in | input | NPH | PWM leg command per phase |
| ph_en | input | NPH | Per-phase drive enable, active high |
| out_en | input | 1 | Global drive enable, active high |
| hi_drv | output | NPH | High-side switch drive per phase |
| lo_drv | output | NPH | Low-side switch drive per phase |

## Verification
The bench checks edge-exact timing of a clean command change: the clear on the third edge and the rise on the eleventh. A design with one synchronizer stage too many or too few, or a counter that stops one count off, lands a cycle early or late. Noise pulses of one, three and seven cycles must not leak through, and the rise must be measured from the last change. A counter that kept counting across a change would fire the opposite drive early and overlap. The enable tests read the drives a fraction of a cycle after each enable moves. A registered gate, or a counter frozen while disabled, shows up as stale drives when an enable is raised.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // Number of bits needed to hold values 0..cycles inclusive.
  function automatic int dt_cnt_bits(input int cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dt_phase.sv
module dt_phase #(
  parameter int DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,
  output logic hi_q,
  output logic lo_q
);
  localparam int CW = dt_pkg::dt_cnt_bits(DEAD_CYC);
  localparam logic [CW-1:0] DEAD = CW'(DEAD_CYC);

  // Saturating step of the stability counter.
  function automatic logic [CW-1:0] cnt_step(input logic [CW-1:0] c);
    return (c == DEAD) ? c : c + 1'b1;
  endfunction

  logic          last_q;
  logic [CW-1:0] cnt_q;
  logic          edge_seen;   // synchronized command differs from last cycle
  logic          settle_now;  // this edge completes the deadtime

  assign edge_seen  = cmd ^ last_q;
  assign settle_now = !edge_seen && (cnt_q != DEAD) && (cnt_step(cnt_q) == DEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      cnt_q  <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      last_q <= cmd;
      if (edge_seen) begin
        cnt_q <= '0;
        hi_q  <= 1'b0;
        lo_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_step(cnt_q);
        if (settle_now) begin
          hi_q <= cmd;
          lo_q <= !cmd;
        end
      end
    end
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> (!hi_q && !lo_q));

  assert_rise_after_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_q) || $rose(lo_q)) |-> ($past(cnt_q) == DEAD - 1'b1 && cnt_q == DEAD));

  assert_settled_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == DEAD && !edge_seen) |-> (hi_q == cmd && lo_q == !cmd));

  assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!hi_q && !lo_q));
endmodule

// File: rtl/dt_gate.sv
module dt_gate (
  input  logic hi_i,
  input  logic lo_i,
  input  logic ph_on,
  input  logic all_on,
  output logic hi_o,
  output logic lo_o
);
  logic pass;
  assign pass = ph_on & all_on;
  assign hi_o = hi_i & pass;
  assign lo_o = lo_i & pass;
endmodule

// File: rtl/pwm_deadtime3.sv
module pwm_deadtime3 #(
  parameter int NPH         = 3,
  parameter int DEAD_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] ph_in,
  input  logic [NPH-1:0] ph_en,
  input  logic           out_en,
  output logic [NPH-1:0] hi_drv,
  output logic [NPH-1:0] lo_drv
);
  logic [NPH-1:0] cmd_sync;
  logic [NPH-1:0] hi_raw;
  logic [NPH-1:0] lo_raw;

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    dt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ph_in[g]), .q(cmd_sync[g])
    );

    dt_phase #(.DEAD_CYC(DEAD_CYC)) u_core (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_sync[g]),
      .hi_q(hi_raw[g]), .lo_q(lo_raw[g])
    );

    dt_gate u_gate (
      .hi_i(hi_raw[g]), .lo_i(lo_raw[g]), .ph_on(ph_en[g]), .all_on(out_en),
      .hi_o(hi_drv[g]), .lo_o(lo_drv[g])
    );

    assert_phase_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ph_en[g] |-> (!hi_drv[g] && !lo_drv[g]));

    assert_enabled_shows_core_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_en[g] && out_en) |-> (hi_drv[g] == hi_raw[g] && lo_drv[g] == lo_raw[g]));
  end

  assert_global_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (hi_drv == '0 && lo_drv == '0));
endmodule

// File: tb/test_pwm_deadtime3.sv
module test_pwm_deadtime3;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ph_in, ph_en;
  logic       out_en;
  logic [2:0] hi_drv, lo_drv;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int lowcnt [3];
  logic [2:0] prev_hi = '0, prev_lo = '0;
  logic [2:0] exp_hi = '0, exp_lo = '0;

  always #5 clk = ~clk;  // 100 MHz

  pwm_deadtime3 i_pwm_deadtime3 (
    .clk(clk), .rst_n(rst_n), .ph_in(ph_in), .ph_en(ph_en), .out_en(out_en),
    .hi_drv(hi_drv), .lo_drv(lo_drv)
  );

  task automatic chk(input string req, input string what,
                     input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] masked(input int p);
    logic [2:0] m;
    m = ~(3'b001 << p);
    return {exp_hi & m, exp_lo & m};
  endfunction

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Continuous watch: R2 overlap and R3 minimum low run before any rise.
  always @(negedge clk) begin
    for (int p = 0; p < 3; p++) begin
      if (rst_n) begin
        checks++;
        if (hi_drv[p] && lo_drv[p]) begin
          errors++;
          $display("FAIL R2 phase %0d overlap: actual hi=1 lo=1 expected not both", p);
        end
        if (mon_on && ((hi_drv[p] && !prev_hi[p]) || (lo_drv[p] && !prev_lo[p]))) begin
          checks++;
          if (lowcnt[p] < 8) begin
            errors++;
            $display("FAIL R3 phase %0d rise after low run: actual %0d expected >= 8", p, lowcnt[p]);
          end
        end
      end
      if (!mon_on) lowcnt[p] = 99;
      else if (!hi_drv[p] && !lo_drv[p]) lowcnt[p] = lowcnt[p] + 1;
      else lowcnt[p] = 0;
    end
    prev_hi = hi_drv;
    prev_lo = lo_drv;
  end

  task automatic t_reset();
    rst_n = 1'b0; ph_in = '0; ph_en = '1; out_en = 1'b1;
    for (int p = 0; p < 3; p++) lowcnt[p] = 0;
    mon_on = 1'b1;
    wait_neg(3);
    chk("R6", "drives in reset", {hi_drv, lo_drv}, 6'b0);
    rst_n = 1'b1;
    wait_neg(7);
    chk("R6", "seventh edge after release", {hi_drv, lo_drv}, 6'b0);
    wait_neg(1);
    exp_lo = 3'b111;
    chk("R6", "eighth edge after release", {hi_drv, lo_drv}, {exp_hi, exp_lo});
  endtask

  task automatic t_flip(input int p, input logic v);
    ph_in[p] = v;
    wait_neg(2);
    chk("R4", "before clear", {hi_drv, lo_drv}, {exp_hi, exp_lo});
    wait_neg(1);
    chk("R4", "cleared on third edge", {hi_drv, lo_drv}, masked(p));
    wait_neg(7);
    chk("R3", "still dead at tenth edge", {hi_drv, lo_drv}, masked(p));
    wait_neg(1);
    exp_hi[p] = v; exp_lo[p] = !v;
    chk("R1", "settled drive", {hi_drv, lo_drv}, {exp_hi, exp_lo});
  endtask

  task automatic t_noise(input int p, input int w);
    logic v;
    v = ph_in[p];
    ph_in[p] = !v;
    wait_neg(w);
    ph_in[p] = v;
    for (int k = w + 1; k <= w + 10; k++) begin
      wait_neg(1);
      if (k >= 3) chk("R5", "filtered pulse", {hi_drv, lo_drv}, masked(p));
      else        chk("R5", "before clear", {hi_drv, lo_drv}, {exp_hi, exp_lo});
    end
    wait_neg(1);
    chk("R5", "restored after last change", {hi_drv, lo_drv}, {exp_hi, exp_lo});
  endtask

  task automatic t_global();
    wait_neg(1);
    #2 out_en = 1'b0;
    #1 chk("R8", "global off", {hi_drv, lo_drv}, 6'b0);
    #1 out_en = 1'b1;
    #1 chk("R8", "global back on", {hi_drv, lo_drv}, {exp_hi, exp_lo});
  endtask

  task automatic t_phase_en(input int p);
    wait_neg(1);
    #2 ph_en[p] = 1'b0;
    mon_on = 1'b0;
    #1 chk("R7", "single phase off", {hi_drv, lo_drv}, masked(p));
    wait_neg(1);
    ph_in[p] = !ph_in[p];
    exp_hi[p] = ph_in[p]; exp_lo[p] = !ph_in[p];
    wait_neg(12);
    #2 ph_en[p] = 1'b1;
    #1 chk("R9", "settled state revealed", {hi_drv, lo_drv}, {exp_hi, exp_lo});
    #1 ph_en[p] = 1'b0;
    wait_neg(1);
    ph_in[p] = !ph_in[p];
    wait_neg(5);
    #2 ph_en[p] = 1'b1;
    #1 chk("R9", "mid-deadtime revealed", {hi_drv, lo_drv}, masked(p));
    wait_neg(6);
    exp_hi[p] = ph_in[p]; exp_lo[p] = !ph_in[p];
    chk("R9", "counter ran while off", {hi_drv, lo_drv}, {exp_hi, exp_lo});
    #2 mon_on = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    wait_neg(1);
    t_flip(0, 1'b1);
    t_flip(2, 1'b1);
    t_flip(0, 1'b0);
    t_flip(1, 1'b1);
    t_noise(1, 1);
    t_noise(1, 3);
    t_noise(2, 7);
    t_global();
    t_phase_en(0);
    t_phase_en(2);
    wait_neg(3);
    summary();
    $finish;
  end
endmodule